// File: doc/BRIEF.md
# Interrupt Priority Save/Restore Stack

This block keeps track of the priority level at which the processor is currently running. When an interrupt is taken, it saves that level on a last-in first-out stack and raises the level to the priority of the request being taken. When the handler finishes, it restores the saved level. It sits behind a plain 32-bit register bus with read and write strobes, byte enables and registered read data. The winning request's vector number and priority arrive as plain inputs from an arbiter outside the block.

Two vectoring modes are supported. In software vector mode, a read of the acknowledge register returns the pending vector, shifted into a table-offset position, and performs the save and raise in the same cycle. Because the read has side effects, software must never read it speculatively. In hardware vector mode the same read is free of side effects, and a one-cycle hardware acknowledge pulse performs the save and raise instead. In either mode, any write to the end-of-interrupt register restores the saved level, whatever the data and whichever bytes are enabled. In hardware mode, an acknowledge pulse in the same cycle as an end-of-interrupt write is merged into a single step. A full-stack save and an empty-stack restore are dropped, and each sets a sticky error flag.

Top module: `prio_stack_top`

## Requirements
- R1: After reset, the current priority is 0, the stack is empty, both error flags are clear, the block is in software vector mode and the read data is 0.
- R2: In software vector mode, a read at offset 0x10 returns the pending vector in bits [10:2] with all other bits 0. On that same clock edge, the current priority is pushed and the current priority takes the pending priority. The result does not depend on the byte enables.
- R3: A push while 15 priorities are stored is dropped. The current priority and the stack are left unchanged, and the overflow flag (STATUS bit 0) sets and stays set until it is cleared.
- R4: Any write at offset 0x18 pops the most recently saved priority into the current priority, regardless of the write data and the byte enables (including none enabled).
- R5: An end-of-interrupt write with an empty stack leaves the current priority unchanged and sets the underflow flag (STATUS bit 1).
- R6: A read at offset 0x18 returns 0 and leaves the stack and the current priority unchanged.
- R7: In hardware vector mode, a read at offset 0x10 returns the vector and has no side effect, while a pulse on `hw_ack_i` pushes and raises. In software vector mode `hw_ack_i` is ignored.
- R8: In hardware vector mode, a `hw_ack_i` pulse in the same cycle as an end-of-interrupt write, with a non-empty stack, loads the pending priority and leaves the stack contents and depth unchanged.
- R9: A write at offset 0x08 with byte enable 0 set loads the current priority from wdata[3:0], and the register reads back there. A write at offset 0x00 with byte enable 0 set selects hardware vector mode when wdata bit 0 is 1 and software mode when it is 0.
- R10: A read at offset 0x1C returns the stack depth in bits [11:8]. A write there with byte enable 0 set clears the overflow flag where wdata bit 0 is 1 and the underflow flag where wdata bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| pend_vec_i | input | 9 | Vector number of the pending request |
| pend_pri_i | input | 4 | Priority of the pending request |
| hw_ack_i | input | 1 | Hardware acknowledge pulse (hardware vector mode) |
| cur_pri_o | output | 4 | Current priority |

## Verification
The bench fills the stack to exactly 15 entries and then tries one more acknowledge. A design with an off-by-one depth check would either accept the sixteenth push, corrupting the count, or refuse the fifteenth. It pops an empty stack and checks that the current priority holds. It sends end-of-interrupt writes with junk data and with no byte enables; a design that decoded the data or the enables would skip the pop. It merges a hardware acknowledge with an end-of-interrupt write, where a design that ignored either event would leave the wrong priority or the wrong depth. It also reads the acknowledge register in hardware mode, where a design with a stray side effect would change the priority.

// File: rtl/prio_stk_pkg.sv
package prio_stk_pkg;
   // word offsets (byte address bits [7:2])
   localparam logic [5:0] WOFS_CTRL   = 6'h00;
   localparam logic [5:0] WOFS_CURPRI = 6'h02;
   localparam logic [5:0] WOFS_ACK    = 6'h04;
   localparam logic [5:0] WOFS_EOI    = 6'h06;
   localparam logic [5:0] WOFS_STAT   = 6'h07;

   typedef enum logic [1:0] {
      STK_IDLE = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_op_e;
endpackage

// File: rtl/prio_lifo.sv
module prio_lifo
   import prio_stk_pkg::*;
#(
   parameter int PRI_W = 4,
   parameter int DEPTH = 15,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  stk_op_e          op_i,
   input  logic [PRI_W-1:0] push_data_i,
   output logic [PRI_W-1:0] top_o,
   output logic [CNT_W-1:0] depth_o
);
   logic [PRI_W-1:0] slot_q [DEPTH];
   logic [CNT_W-1:0] cnt_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            slot_q[g] <= '0;
         else if (op_i == STK_PUSH && cnt_q == CNT_W'(g))
            slot_q[g] <= push_data_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (op_i == STK_PUSH)
         cnt_q <= cnt_q + 1'b1;
      else if (op_i == STK_POP)
         cnt_q <= cnt_q - 1'b1;
   end

   always_comb begin
      top_o = '0;
      for (int i = 0; i < DEPTH; i++)
         if (cnt_q == CNT_W'(i + 1)) top_o = slot_q[i];
   end

   assign depth_o = cnt_q;
endmodule

// File: rtl/prio_bus_dec.sv
module prio_bus_dec
   import prio_stk_pkg::*;
(
   input  logic       rd_i,
   input  logic       wr_i,
   input  logic [7:0] addr_i,
   input  logic [3:0] be_i,
   output logic       ack_rd_o,
   output logic       eoi_wr_o,
   output logic       ctrl_wr_o,
   output logic       cur_wr_o,
   output logic       stat_wr_o
);
   logic [5:0] wofs;
   assign wofs = addr_i[7:2];

   // acknowledge and end-of-interrupt decode ignore byte enables
   assign ack_rd_o  = rd_i && (wofs == WOFS_ACK);
   assign eoi_wr_o  = wr_i && (wofs == WOFS_EOI);
   assign ctrl_wr_o = wr_i && (wofs == WOFS_CTRL)   && be_i[0];
   assign cur_wr_o  = wr_i && (wofs == WOFS_CURPRI) && be_i[0];
   assign stat_wr_o = wr_i && (wofs == WOFS_STAT)   && be_i[0];
endmodule

// File: rtl/prio_stk_ctrl.sv
module prio_stk_ctrl
   import prio_stk_pkg::*;
#(
   parameter int PRI_W = 4,
   parameter int DEPTH = 15,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             hw_mode_i,
   input  logic             ack_rd_i,
   input  logic             hw_ack_i,
   input  logic             eoi_wr_i,
   input  logic             cur_wr_i,
   input  logic [PRI_W-1:0] cur_wdata_i,
   input  logic [PRI_W-1:0] pend_pri_i,
   input  logic [PRI_W-1:0] top_i,
   input  logic [CNT_W-1:0] depth_i,
   output stk_op_e          op_o,
   output logic [PRI_W-1:0] cur_o,
   output logic             ovf_set_o,
   output logic             unf_set_o
);
   logic [PRI_W-1:0] cur_q, cur_d;
   logic ack_evt, full, empty;

   assign ack_evt = hw_mode_i ? hw_ack_i : ack_rd_i;
   assign full    = (depth_i == CNT_W'(DEPTH));
   assign empty   = (depth_i == '0);

   always_comb begin
      op_o      = STK_IDLE;
      cur_d     = cur_q;
      ovf_set_o = 1'b0;
      unf_set_o = 1'b0;
      if (ack_evt && eoi_wr_i) begin
         // merged step: restore then save the restored level
         if (empty) begin
            unf_set_o = 1'b1;
            op_o      = STK_PUSH;
         end
         cur_d = pend_pri_i;
      end else if (ack_evt) begin
         if (full) ovf_set_o = 1'b1;
         else begin
            op_o  = STK_PUSH;
            cur_d = pend_pri_i;
         end
      end else if (eoi_wr_i) begin
         if (empty) unf_set_o = 1'b1;
         else begin
            op_o  = STK_POP;
            cur_d = top_i;
         end
      end else if (cur_wr_i) begin
         cur_d = cur_wdata_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) cur_q <= '0;
      else         cur_q <= cur_d;
   end

   assign cur_o = cur_q;
endmodule

// File: rtl/prio_stack_top.sv
module prio_stack_top
   import prio_stk_pkg::*;
#(
   parameter int PRI_W     = 4,
   parameter int DEPTH     = 15,
   parameter int VEC_W     = 9,
   parameter int VEC_SHIFT = 2,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bus_rd_i,
   input  logic             bus_wr_i,
   input  logic [7:0]       bus_addr_i,
   input  logic [3:0]       bus_be_i,
   input  logic [31:0]      bus_wdata_i,
   output logic [31:0]      bus_rdata_o,
   input  logic [VEC_W-1:0] pend_vec_i,
   input  logic [PRI_W-1:0] pend_pri_i,
   input  logic             hw_ack_i,
   output logic [PRI_W-1:0] cur_pri_o
);
   if (DEPTH < 1 || DEPTH > 255) begin : g_bad_depth
      $error("DEPTH must be 1..255");
   end
   if (PRI_W < 1 || PRI_W > 8) begin : g_bad_pri
      $error("PRI_W must be 1..8");
   end
   if (VEC_W + VEC_SHIFT >= 32) begin : g_bad_vec
      $error("VEC_W + VEC_SHIFT must be below 32");
   end

   logic ack_rd, eoi_wr, ctrl_wr, cur_wr, stat_wr;
   logic hw_mode_q, ovf_q, unf_q, ovf_set, unf_set, ovf_clr, unf_clr;
   stk_op_e          stk_op;
   logic [PRI_W-1:0] stk_top;
   logic [CNT_W-1:0] stk_depth;
   logic [31:0]      ack_word, rd_mux;

   prio_bus_dec u_dec (
      .rd_i(bus_rd_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i), .be_i(bus_be_i),
      .ack_rd_o(ack_rd), .eoi_wr_o(eoi_wr), .ctrl_wr_o(ctrl_wr),
      .cur_wr_o(cur_wr), .stat_wr_o(stat_wr)
   );

   prio_stk_ctrl #(.PRI_W(PRI_W), .DEPTH(DEPTH)) u_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .hw_mode_i(hw_mode_q),
      .ack_rd_i(ack_rd), .hw_ack_i(hw_ack_i), .eoi_wr_i(eoi_wr),
      .cur_wr_i(cur_wr), .cur_wdata_i(bus_wdata_i[PRI_W-1:0]),
      .pend_pri_i(pend_pri_i), .top_i(stk_top), .depth_i(stk_depth),
      .op_o(stk_op), .cur_o(cur_pri_o),
      .ovf_set_o(ovf_set), .unf_set_o(unf_set)
   );

   prio_lifo #(.PRI_W(PRI_W), .DEPTH(DEPTH)) u_lifo (
      .clk_i(clk_i), .rst_ni(rst_ni), .op_i(stk_op),
      .push_data_i(cur_pri_o), .top_o(stk_top), .depth_o(stk_depth)
   );

   assign ovf_clr = stat_wr && bus_wdata_i[0];
   assign unf_clr = stat_wr && bus_wdata_i[1];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hw_mode_q <= 1'b0;
         ovf_q     <= 1'b0;
         unf_q     <= 1'b0;
      end else begin
         if (ctrl_wr) hw_mode_q <= bus_wdata_i[0];
         ovf_q <= ovf_set | (ovf_q & ~ovf_clr);
         unf_q <= unf_set | (unf_q & ~unf_clr);
      end
   end

   if (VEC_SHIFT == 0) begin : g_vec_flat
      assign ack_word = {{(32-VEC_W){1'b0}}, pend_vec_i};
   end else begin : g_vec_shift
      assign ack_word = {{(32-VEC_W-VEC_SHIFT){1'b0}}, pend_vec_i, {VEC_SHIFT{1'b0}}};
   end

   always_comb begin
      unique case (bus_addr_i[7:2])
         WOFS_CTRL:   rd_mux = {31'b0, hw_mode_q};
         WOFS_CURPRI: rd_mux = {{(32-PRI_W){1'b0}}, cur_pri_o};
         WOFS_ACK:    rd_mux = ack_word;
         WOFS_STAT:   rd_mux = {16'b0, {(8-CNT_W){1'b0}}, stk_depth, 6'b0, unf_q, ovf_q};
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)       bus_rdata_o <= '0;
      else if (bus_rd_i) bus_rdata_o <= rd_mux;
   end
endmodule

// File: rtl/prio_stk_chk.sv
module prio_stk_chk #(
   parameter int PRI_W = 4,
   parameter int DEPTH = 15,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             hw_mode_q,
   input logic             ack_rd,
   input logic             hw_ack_i,
   input logic             eoi_wr,
   input logic             cur_wr,
   input logic [PRI_W-1:0] pend_pri_i,
   input logic [PRI_W-1:0] cur_pri_o,
   input logic [CNT_W-1:0] stk_depth,
   input logic             ovf_q,
   input logic             unf_q,
   input logic             ovf_clr
);
   logic ack_any;
   assign ack_any = hw_mode_q ? hw_ack_i : ack_rd;

   p_depth_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stk_depth <= CNT_W'(DEPTH));

   p_sw_ack_raise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hw_mode_q && ack_rd && !eoi_wr && stk_depth < CNT_W'(DEPTH))
      |=> (cur_pri_o == $past(pend_pri_i)) && (stk_depth == CNT_W'($past(stk_depth) + 1'b1)));

   p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_any && !eoi_wr && stk_depth == CNT_W'(DEPTH))
      |=> ovf_q && $stable(cur_pri_o) && $stable(stk_depth));

   p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q && !ovf_clr) |=> ovf_q);

   p_empty_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_wr && !ack_any && stk_depth == '0) |=> unf_q && $stable(cur_pri_o));

   p_hw_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_mode_q && !hw_ack_i && !eoi_wr && !cur_wr)
      |=> $stable(stk_depth) && $stable(cur_pri_o));

   p_merge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_mode_q && hw_ack_i && eoi_wr && stk_depth != '0)
      |=> $stable(stk_depth) && (cur_pri_o == $past(pend_pri_i)));
endmodule

bind prio_stack_top prio_stk_chk #(.PRI_W(PRI_W), .DEPTH(DEPTH)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .hw_mode_q(hw_mode_q), .ack_rd(ack_rd),
   .hw_ack_i(hw_ack_i), .eoi_wr(eoi_wr), .cur_wr(cur_wr),
   .pend_pri_i(pend_pri_i), .cur_pri_o(cur_pri_o), .stk_depth(stk_depth),
   .ovf_q(ovf_q), .unf_q(unf_q), .ovf_clr(ovf_clr)
);

// File: tb/prio_stack_top_bench.sv
module prio_stack_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd = 1'b0, wr = 1'b0, hw_ack = 1'b0;
   logic [7:0]  addr = '0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [8:0]  vec = '0;
   logic [3:0]  pri = '0;
   logic [3:0]  cur;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   prio_stack_top u_prio_stack_top (
      .clk_i(clk), .rst_ni(rst_n), .bus_rd_i(rd), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .pend_vec_i(vec), .pend_pri_i(pri), .hw_ack_i(hw_ack), .cur_pri_o(cur)
   );

   // kind: 0 read, 1 write, 2 hw ack pulse, 3 hw ack with end-of-interrupt write
   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  a;
      logic [31:0] wd;
      logic [3:0]  b;
      logic [8:0]  v;
      logic [3:0]  p;
      logic        chk_rd;
      logic [31:0] exp_rd;
      logic [3:0]  exp_cur;
      logic [3:0]  req;
   } row_t;

   localparam int NROW = 20;
   localparam row_t TBL [NROW] = '{
      '{2'd0, 8'h10, 32'h0,        4'hF, 9'd5,     4'd3,  1'b1, 32'h14,  4'd3,  4'd2},  // R2
      '{2'd0, 8'h10, 32'h0,        4'h1, 9'h1FF,   4'd7,  1'b1, 32'h7FC, 4'd7,  4'd2},  // R2 byte read
      '{2'd0, 8'h18, 32'h0,        4'hF, 9'd0,     4'd1,  1'b1, 32'h0,   4'd7,  4'd6},  // R6
      '{2'd1, 8'h18, 32'hDEAD,     4'h2, 9'd0,     4'd1,  1'b0, 32'h0,   4'd3,  4'd4},  // R4
      '{2'd1, 8'h18, 32'h0,        4'h0, 9'd0,     4'd1,  1'b0, 32'h0,   4'd0,  4'd4},  // R4 no enables
      '{2'd1, 8'h18, 32'h0,        4'hF, 9'd0,     4'd1,  1'b0, 32'h0,   4'd0,  4'd5},  // R5
      '{2'd0, 8'h1C, 32'h0,        4'hF, 9'd0,     4'd1,  1'b1, 32'h2,   4'd0,  4'd5},  // R5
      '{2'd1, 8'h1C, 32'h2,        4'h1, 9'd0,     4'd1,  1'b0, 32'h0,   4'd0,  4'd10}, // R10
      '{2'd0, 8'h1C, 32'h0,        4'hF, 9'd0,     4'd1,  1'b1, 32'h0,   4'd0,  4'd10}, // R10
      '{2'd1, 8'h08, 32'h9,        4'h1, 9'd0,     4'd1,  1'b0, 32'h0,   4'd9,  4'd9},  // R9
      '{2'd1, 8'h08, 32'h4,        4'h2, 9'd0,     4'd1,  1'b0, 32'h0,   4'd9,  4'd9},  // R9
      '{2'd0, 8'h08, 32'h0,        4'hF, 9'd0,     4'd1,  1'b1, 32'h9,   4'd9,  4'd9},  // R9
      '{2'd2, 8'h00, 32'h0,        4'h0, 9'd3,     4'd12, 1'b0, 32'h0,   4'd9,  4'd7},  // R7
      '{2'd1, 8'h00, 32'h1,        4'h1, 9'd0,     4'd1,  1'b0, 32'h0,   4'd9,  4'd9},  // R9
      '{2'd0, 8'h10, 32'h0,        4'hF, 9'd6,     4'd11, 1'b1, 32'h18,  4'd9,  4'd7},  // R7
      '{2'd2, 8'h00, 32'h0,        4'h0, 9'd6,     4'd11, 1'b0, 32'h0,   4'd11, 4'd7},  // R7
      '{2'd3, 8'h18, 32'h0,        4'hF, 9'd8,     4'd13, 1'b0, 32'h0,   4'd13, 4'd8},  // R8
      '{2'd0, 8'h1C, 32'h0,        4'hF, 9'd0,     4'd1,  1'b1, 32'h100, 4'd13, 4'd8},  // R8
      '{2'd1, 8'h18, 32'h0,        4'hF, 9'd0,     4'd1,  1'b0, 32'h0,   4'd9,  4'd8},  // R8
      '{2'd1, 8'h00, 32'h0,        4'h1, 9'd0,     4'd1,  1'b0, 32'h0,   4'd9,  4'd9}   // R9
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] kind, input logic [7:0] a, input logic [31:0] wd,
                        input logic [3:0] b, input logic [8:0] v, input logic [3:0] p);
      @(negedge clk);
      addr = a; wdata = wd; be = b; vec = v; pri = p;
      rd = (kind == 2'd0);
      wr = (kind == 2'd1) || (kind == 2'd3);
      hw_ack = (kind == 2'd2) || (kind == 2'd3);
      @(posedge clk);
      #1;
      rd = 1'b0; wr = 1'b0; hw_ack = 1'b0;
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      apply_reset();
      #1;
      check("R1 cur", {28'b0, cur}, 32'h0);
      check("R1 rdata", rdata, 32'h0);
      do_op(2'd0, 8'h1C, 32'h0, 4'hF, 9'd0, 4'd0);
      check("R1 status", rdata, 32'h0);
      do_op(2'd0, 8'h00, 32'h0, 4'hF, 9'd0, 4'd0);
      check("R1 ctrl", rdata, 32'h0);

      for (int i = 0; i < NROW; i++) begin
         do_op(TBL[i].kind, TBL[i].a, TBL[i].wd, TBL[i].b, TBL[i].v, TBL[i].p);
         if (TBL[i].chk_rd)
            check($sformatf("R%0d row %0d rdata", TBL[i].req, i), rdata, TBL[i].exp_rd);
         check($sformatf("R%0d row %0d cur", TBL[i].req, i), {28'b0, cur}, {28'b0, TBL[i].exp_cur});
      end

      // R3: fill to 15, then one push too many
      apply_reset();
      for (int i = 0; i < 15; i++)
         do_op(2'd0, 8'h10, 32'h0, 4'hF, 9'(i), 4'(i + 1));
      check("R3 cur at full", {28'b0, cur}, 32'hF);
      do_op(2'd0, 8'h10, 32'h0, 4'hF, 9'd2, 4'd2);
      check("R3 rdata on dropped ack", rdata, 32'h8);
      check("R3 cur after dropped push", {28'b0, cur}, 32'hF);
      do_op(2'd0, 8'h1C, 32'h0, 4'hF, 9'd0, 4'd0);
      check("R3 status full+ovf", rdata, 32'hF01);
      do_op(2'd1, 8'h18, 32'h0, 4'hF, 9'd0, 4'd0);
      check("R4 pop after full", {28'b0, cur}, 32'hE);
      do_op(2'd0, 8'h1C, 32'h0, 4'hF, 9'd0, 4'd0);
      check("R3 ovf sticky", rdata, 32'hE01);
      do_op(2'd1, 8'h1C, 32'h1, 4'h1, 9'd0, 4'd0);
      do_op(2'd0, 8'h1C, 32'h0, 4'hF, 9'd0, 4'd0);
      check("R10 ovf cleared", rdata, 32'hE00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule